// File: doc/BRIEF.md
# E1 Receive Alarm Monitor

This block watches the receive side of an E1 link and reports two alarm conditions to the control logic. The first is carrier loss, raised when the recovered line data shows a long unbroken run of zeros. The second is the signaling all-ones alarm, judged once per signaling multiframe from the number of zero bits seen in timeslot 16. Each alarm is available as a live level, as a sticky status bit and as an interrupt source.

Line data arrives as one bit per `line_vld` strobe. Aligned frame data arrives as one bit per `frm_vld` strobe, together with its timeslot number and a strobe that marks the first bit of each 16-frame signaling multiframe. Every change of an alarm, rising or falling, records a pending interrupt for that source. `irq_n` goes low while an enabled source is pending. A host clear pulse removes the pending flag. It also removes the sticky bit, unless the alarm is still present. Bit index 0 of every two-bit vector is carrier loss and index 1 is signaling all-ones.

Top module: `e1_rx_alarm_mon`

## Requirements
- R1: With `long_run_sel`=0, `los` rises after the 255th consecutive zero on the line strobe and stays low after 254.
- R2: With `long_run_sel`=1, `los` rises after the 2048th consecutive zero and stays low after 2047.
- R3: A line one clears `los` and restarts the zero run from nothing.
- R4: At a multiframe start, `sig_ais` is set if the window just ended held fewer than three zeros in timeslot 16.
- R5: At a multiframe start, `sig_ais` is cleared if the window just ended held three or more zeros in timeslot 16.
- R6: Zeros in any timeslot other than 16 do not count toward the signaling window.
- R7: The first multiframe start after reset closes no window and leaves `sig_ais` low.
- R8: Any change of an alarm, rising or falling, marks that source pending, and `irq_n` goes low while a pending source has its `irq_en` bit at 1.
- R9: A source whose `irq_en` bit is 0 never pulls `irq_n` low. Its pending flag is still recorded and drives `irq_n` low once the bit is set to 1.
- R10: `alarm_latch` sets when its alarm rises. A `host_clr` pulse clears it only if the alarm is gone. If the alarm is still present, the bit stays set.
- R11: `irq_n` returns high once every enabled pending source has been cleared by `host_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_vld | input | 1 | Strobe for one recovered line bit |
| line_bit | input | 1 | Recovered line bit, 1 = mark |
| long_run_sel | input | 1 | 0 = 255-zero threshold, 1 = 2048-zero threshold |
| frm_vld | input | 1 | Strobe for one aligned frame bit |
| frm_bit | input | 1 | Aligned frame bit |
| frm_slot | input | 5 | Timeslot of the current frame bit |
| mf_start | input | 1 | With `frm_vld`, marks the first bit of a signaling multiframe |
| irq_en | input | 2 | Interrupt enables, 1 = enabled |
| host_clr | input | 2 | One-cycle clear of pending and sticky bits |
| los | output | 1 | Live carrier-loss alarm |
| sig_ais | output | 1 | Live signaling all-ones alarm |
| alarm_latch | output | 2 | Sticky alarm bits |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest state to reach is a host clear that arrives while the alarm is still active. The sticky bit must survive it, but the pending flag must not. A second hard state is a signaling alarm that changes while its source is masked. The bench holds carrier loss with an exact zero run, pulses the clear, and then checks the sticky bit and `irq_n` separately. It then masks the signaling source and drives two multiframes whose timeslot 16 zero counts toggle the alarm. After that it enables the mask and looks for the delayed interrupt. Random zero-run lengths cluster around 255, and random zero counts cluster around three, so both thresholds are crossed from either side.

// File: rtl/e1_rx_alarm_mon.sv
module e1_rx_alarm_mon #(
  parameter int SHORT_RUN     = 255,
  parameter int LONG_RUN      = 2048,
  parameter int SIG_SLOT      = 16,
  parameter int SIG_MIN_ZEROS = 3,
  parameter int SLOT_W        = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_vld,
  input  logic              line_bit,
  input  logic              long_run_sel,
  input  logic              frm_vld,
  input  logic              frm_bit,
  input  logic [SLOT_W-1:0] frm_slot,
  input  logic              mf_start,
  input  logic [1:0]        irq_en,
  input  logic [1:0]        host_clr,
  output logic              los,
  output logic              sig_ais,
  output logic [1:0]        alarm_latch,
  output logic              irq_n
);
  localparam int RUN_W = $clog2(LONG_RUN + 1);
  localparam int ZC_W  = $clog2(SIG_MIN_ZEROS + 1);
  localparam logic [RUN_W-1:0]  SHORT_V = RUN_W'(SHORT_RUN);
  localparam logic [RUN_W-1:0]  LONG_V  = RUN_W'(LONG_RUN);
  localparam logic [ZC_W-1:0]   ZMIN_V  = ZC_W'(SIG_MIN_ZEROS);
  localparam logic [SLOT_W-1:0] SLOT_V  = SLOT_W'(SIG_SLOT);

  logic [RUN_W-1:0] run_cnt;
  logic [RUN_W-1:0] run_nxt;
  logic [RUN_W-1:0] run_thr;
  logic [ZC_W-1:0]  zc;
  logic             armed;
  logic             sig_zero;
  logic [1:0]       alarms, alarm_d, chg, rise, pend;

  assign run_thr  = long_run_sel ? LONG_V : SHORT_V;
  assign run_nxt  = (run_cnt == LONG_V) ? run_cnt : run_cnt + 1'b1;
  assign sig_zero = (frm_slot == SLOT_V) && !frm_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      los     <= 1'b0;
    end else if (line_vld) begin
      if (line_bit) begin
        run_cnt <= '0;
        los     <= 1'b0;
      end else begin
        run_cnt <= run_nxt;
        los     <= (run_nxt >= run_thr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zc      <= '0;
      armed   <= 1'b0;
      sig_ais <= 1'b0;
    end else if (frm_vld) begin
      if (mf_start) begin
        if (armed) sig_ais <= (zc < ZMIN_V);
        armed <= 1'b1;
        zc    <= sig_zero ? ZC_W'(1) : '0;
      end else if (sig_zero && zc != ZMIN_V) begin
        zc <= zc + 1'b1;
      end
    end
  end

  assign alarms = {sig_ais, los};
  assign chg    = alarms ^ alarm_d;
  assign rise   = alarms & ~alarm_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_d     <= '0;
      pend        <= '0;
      alarm_latch <= '0;
    end else begin
      alarm_d     <= alarms;
      pend        <= chg | (pend & ~host_clr);
      alarm_latch <= rise | (alarm_latch & ~host_clr) | (alarms & host_clr);
    end
  end

  assign irq_n = ~|(pend & irq_en);
endmodule

module e1_rx_alarm_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_vld,
  input logic       line_bit,
  input logic       frm_vld,
  input logic       mf_start,
  input logic [1:0] irq_en,
  input logic [1:0] host_clr,
  input logic       los,
  input logic       sig_ais,
  input logic [1:0] alarm_latch,
  input logic       irq_n
);
  assert_los_rise_on_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> $past(line_vld && !line_bit));

  assert_one_clears_los_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_vld && line_bit) |=> !los);

  assert_sig_only_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_vld && mf_start) |=> $stable(sig_ais));

  assert_irq_on_los_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (los != $past(los) && irq_en[0] && $past(irq_en[0])) |=> !irq_n);

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 2'b00) |-> irq_n);

  assert_latch_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (los && host_clr[0]) |=> alarm_latch[0]);
endmodule

bind e1_rx_alarm_mon e1_rx_alarm_mon_chk i_chk (
  .clk(clk), .rst_n(rst_n), .line_vld(line_vld), .line_bit(line_bit),
  .frm_vld(frm_vld), .mf_start(mf_start), .irq_en(irq_en), .host_clr(host_clr),
  .los(los), .sig_ais(sig_ais), .alarm_latch(alarm_latch), .irq_n(irq_n)
);

// File: tb/test_e1_rx_alarm_mon.sv
module test_e1_rx_alarm_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_vld = 1'b0, line_bit = 1'b1, long_run_sel = 1'b0;
  logic       frm_vld = 1'b0, frm_bit = 1'b1, mf_start = 1'b0;
  logic [4:0] frm_slot = '0;
  logic [1:0] irq_en = 2'b00, host_clr = 2'b00;
  logic       los, sig_ais, irq_n;
  logic [1:0] alarm_latch;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit prev_sig;

  always #5 clk = ~clk;

  e1_rx_alarm_mon i_e1_rx_alarm_mon (
    .clk(clk), .rst_n(rst_n), .line_vld(line_vld), .line_bit(line_bit),
    .long_run_sel(long_run_sel), .frm_vld(frm_vld), .frm_bit(frm_bit),
    .frm_slot(frm_slot), .mf_start(mf_start), .irq_en(irq_en), .host_clr(host_clr),
    .los(los), .sig_ais(sig_ais), .alarm_latch(alarm_latch), .irq_n(irq_n)
  );

  function automatic bit exp_sig(int zeros);
    return zeros < 3;
  endfunction

  function automatic bit exp_los(int run, bit long_sel);
    return run >= (long_sel ? 2048 : 255);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic line_run(int n, bit b);
    repeat (n) begin
      line_vld = 1'b1; line_bit = b;
      @(negedge clk);
    end
    line_vld = 1'b0; line_bit = 1'b1;
    @(negedge clk);
  endtask

  task automatic clear(logic [1:0] v);
    host_clr = v;
    @(negedge clk);
    host_clr = 2'b00;
    @(negedge clk);
  endtask

  // one multiframe; zeros placed only in timeslot 16 count (R6: every other slot carries zeros)
  task automatic run_mf(int z);
    int k = 0;
    for (int fr = 0; fr < 16; fr++)
      for (int ts = 0; ts < 32; ts++)
        for (int b = 0; b < 8; b++) begin
          frm_vld  = 1'b1;
          mf_start = (fr == 0 && ts == 0 && b == 0);
          frm_slot = ts[4:0];
          if (ts == 16) begin
            frm_bit = !((k % 16) == 5 && (k / 16) < z);
            k++;
          end else begin
            frm_bit = 1'b0;
          end
          @(negedge clk);
        end
    frm_vld = 1'b0; mf_start = 1'b0; frm_bit = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset los", los, 0);
    chk("R7 reset sig_ais", sig_ais, 0);
    chk("R10 reset latch", alarm_latch, 0);
    chk("R11 reset irq_n", irq_n, 1);

    irq_en = 2'b11;
    line_run(254, 0);
    chk("R1 254 zeros", los, 0);
    line_run(1, 0);
    chk("R1 255 zeros", los, 1);
    @(negedge clk);
    chk("R8 irq on los rise", irq_n, 0);
    chk("R10 latch set", alarm_latch[0], 1);
    clear(2'b01);
    chk("R10 latch held while los", alarm_latch[0], 1);
    chk("R11 irq released", irq_n, 1);
    line_run(1, 1);
    chk("R3 one clears los", los, 0);
    @(negedge clk);
    chk("R8 irq on los fall", irq_n, 0);
    clear(2'b01);
    chk("R10 latch cleared after alarm gone", alarm_latch[0], 0);
    chk("R11 irq released again", irq_n, 1);

    for (int i = 0; i < 6; i++) begin
      int n = $urandom_range(200, 320);
      line_run(1, 1);
      line_run(n, 0);
      chk("R1 random run", los, exp_los(n, 1'b0));
      line_run(1, 1);
      chk("R3 random one", los, 0);
      clear(2'b11);
    end

    long_run_sel = 1'b1;
    line_run(1, 1);
    line_run(2047, 0);
    chk("R2 2047 zeros", los, 0);
    line_run(1, 0);
    chk("R2 2048 zeros", los, 1);
    line_run(1, 1);
    long_run_sel = 1'b0;
    clear(2'b11);

    run_mf(0);
    chk("R7 first boundary no judgement", sig_ais, 0);
    run_mf(5);
    chk("R4 zero-count window sets alarm", sig_ais, 1);
    chk("R8 irq on sig rise", irq_n, 0);
    chk("R10 sig latch", alarm_latch[1], 1);
    clear(2'b10);
    chk("R11 irq clear sig", irq_n, 1);
    run_mf(1);
    chk("R5 five zeros clears alarm", sig_ais, 0);
    clear(2'b11);
    run_mf(3);
    chk("R6 one ts16 zero with other slots zero", sig_ais, 1);
    clear(2'b11);
    run_mf(2);
    chk("R5 exactly three clears", sig_ais, 0);
    clear(2'b11);
    run_mf(0);
    chk("R4 exactly two sets", sig_ais, 1);
    prev_sig = 1'b1;
    clear(2'b11);
    begin
      int prev_z = 0;
      for (int i = 0; i < 6; i++) begin
        int z = $urandom_range(0, 6);
        run_mf(z);
        chk("R4 R5 random window", sig_ais, exp_sig(prev_z));
        if (exp_sig(prev_z) != prev_sig) chk("R8 random change irq", irq_n, 0);
        prev_sig = exp_sig(prev_z);
        prev_z = z;
        clear(2'b11);
      end
      // R9: mask signaling source, force two changes
      irq_en = 2'b00;
      run_mf(exp_sig(prev_z) ? 6 : 0);
      chk("R9 masked change quiet", irq_n, 1);
      prev_sig = exp_sig(prev_z);
      run_mf(0);
      chk("R9 masked second change quiet", irq_n, 1);
      irq_en = 2'b10;
      @(negedge clk);
      chk("R9 pending seen after unmask", irq_n, 0);
      clear(2'b11);
      chk("R11 all cleared", irq_n, 1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule